// File: doc/BRIEF.md
# Cluster Cross-Halt Propagation Unit

This block spreads a debug halt from one core of a cluster to its peers. Each core reports whether it is halted and which of four causes are active. Software chooses which cores take part through a participation mask. For every core it also chooses which causes may spread. When a participating core is halted for an enabled cause, every other participating core receives a halt request on the following clock edge. That request remains asserted for as long as the condition holds.

The same unit owns a shared free-running counter. A separate freeze mask names the cores whose halt stops that counter. The counter holds its value in any cycle in which a core in that mask reports halted.

All configuration goes through a single command port. A command carries an operation code, a 4-bit cause parameter and a core bitmap. Each read command loads a readback register that software samples afterwards. Every mask resets to zero, so nothing spreads and nothing freezes until software writes the masks.

Top module: `xhalt_unit`

## Requirements
- R1: While reset is held, `rdbk`, `halt_req` and `ctr_value` are zero. Every mask clears to zero.
- R2: The op codes are NOP=0, SET_SELECT=1, READ_SELECT=2, SET_CAUSE=3, READ_CAUSE=4, SET_FREEZE=5 and READ_FREEZE=6. SET_SELECT loads `cmd_data` into the participation mask. READ_SELECT places that mask in `rdbk` on the clock edge that accepts the command.
- R3: SET_CAUSE writes `cmd_param` into the cause mask of every core whose bit is set in `cmd_data`. The cause masks of all other cores are left unchanged. Cause bit 0 is the halt flag, bit 1 an actionpoint, bit 2 a breakpoint and bit 3 a self-halt.
- R4: READ_CAUSE loads `rdbk` with a bitmap that has bit k set when core k's cause mask shares at least one bit with `cmd_param`.
- R5: SET_FREEZE loads `cmd_data` into the counter freeze mask. READ_FREEZE places that mask in `rdbk` on the accepting edge.
- R6: A core triggers when it is in the participation mask, `core_halted` is set for it, and its slice of `halt_cause` (bits 4k+3..4k) overlaps its cause mask. One edge after a trigger, `halt_req[j]` is set for every participating core j other than the triggering core.
- R7: A core never receives a request caused only by its own trigger. A core outside the participation mask never receives a request.
- R8: `halt_req` holds for as long as the triggering condition holds. It clears on the edge after the condition ends.
- R9: `ctr_value` increases by one on each edge, wrapping at 2^CTR_W, when no core in the freeze mask has `core_halted` set.
- R10: `ctr_value` holds its value across an edge when any core in the freeze mask has `core_halted` set.
- R11: An unused op code (7), or any op while `cmd_valid` is low, leaves all masks and `rdbk` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_param | input | 4 | Cause parameter |
| cmd_data | input | NUM_CORES | Core bitmap |
| rdbk | output | NUM_CORES | Readback register |
| core_halted | input | NUM_CORES | Per-core halted status |
| halt_cause | input | 4*NUM_CORES | Active causes per core, 4 bits each |
| halt_req | output | NUM_CORES | Registered halt request per core |
| ctr_value | output | CTR_W | Shared free-running counter |

## Verification
The bench builds the unit with NUM_CORES=4 and CTR_W=16. Each core is given one distinct enabled cause. With a 4-core cluster and a 4-bit cause field, the bench can sweep every participation mask against every halted pattern and every applied cause, which is 4096 combinations, each compared with an expected request vector computed arithmetically. In the same way it sweeps all 256 pairings of freeze mask and halted pattern against the counter step. It also covers the partial cause write, the overlap query, hold and release of a request, and the ignored op codes.

// File: rtl/xhalt_pkg.sv
package xhalt_pkg;

    localparam int CAUSE_W = 4;

    localparam int CAUSE_FLAG   = 0;
    localparam int CAUSE_ACTPT  = 1;
    localparam int CAUSE_BRKPT  = 2;
    localparam int CAUSE_SELF   = 3;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_SET_SELECT = 3'd1,
        OP_RD_SELECT  = 3'd2,
        OP_SET_CAUSE  = 3'd3,
        OP_RD_CAUSE   = 3'd4,
        OP_SET_FREEZE = 3'd5,
        OP_RD_FREEZE  = 3'd6,
        OP_SPARE      = 3'd7
    } xh_op_e;

    typedef struct packed {
        logic               valid;
        xh_op_e             op;
        logic [CAUSE_W-1:0] param;
    } xh_cmd_t;

    function automatic logic cause_hit(input logic [CAUSE_W-1:0] active,
                                       input logic [CAUSE_W-1:0] enabled);
        return |(active & enabled);
    endfunction

endpackage

// File: rtl/xhalt_cfg.sv
module xhalt_cfg
    import xhalt_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  xh_cmd_t                      cmd,
    input  logic [NUM_CORES-1:0]         cmd_data,
    output logic [NUM_CORES-1:0]         sel_mask,
    output logic [NUM_CORES*CAUSE_W-1:0] cause_en,
    output logic [NUM_CORES-1:0]         frz_mask,
    output logic [NUM_CORES-1:0]         rdbk
);

    logic [NUM_CORES-1:0] overlap;
    logic                 wr_sel;
    logic                 wr_cause;
    logic                 wr_frz;
    logic                 rd_any;
    logic [NUM_CORES-1:0] rd_value;

    genvar k;
    generate
        for (k = 0; k < NUM_CORES; k++) begin : g_overlap
            assign overlap[k] = cause_hit(cause_en[k*CAUSE_W +: CAUSE_W], cmd.param);
        end
    endgenerate

    assign wr_sel   = cmd.valid && (cmd.op == OP_SET_SELECT);
    assign wr_cause = cmd.valid && (cmd.op == OP_SET_CAUSE);
    assign wr_frz   = cmd.valid && (cmd.op == OP_SET_FREEZE);

    always_comb begin
        rd_any   = 1'b0;
        rd_value = '0;
        if (cmd.valid) begin
            unique case (cmd.op)
                OP_RD_SELECT: begin rd_any = 1'b1; rd_value = sel_mask; end
                OP_RD_CAUSE:  begin rd_any = 1'b1; rd_value = overlap;  end
                OP_RD_FREEZE: begin rd_any = 1'b1; rd_value = frz_mask; end
                default:      begin rd_any = 1'b0; rd_value = '0;       end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_mask <= '0;
            frz_mask <= '0;
            rdbk     <= '0;
        end else begin
            if (wr_sel) sel_mask <= cmd_data;
            if (wr_frz) frz_mask <= cmd_data;
            if (rd_any) rdbk     <= rd_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_en <= '0;
        end else if (wr_cause) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (cmd_data[c]) cause_en[c*CAUSE_W +: CAUSE_W] <= cmd.param;
            end
        end
    end

    AST_RDBK_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd.valid |=> $stable(rdbk)) else $error("rdbk moved without command"); // R11

    AST_SEL_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
        !(cmd.valid && cmd.op == OP_SET_SELECT) |=> $stable(sel_mask)) else $error("select mask moved"); // R2

    AST_FRZ_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.op == OP_SET_FREEZE) |=> frz_mask == $past(cmd_data)) else $error("freeze mask load"); // R5

endmodule

// File: rtl/xhalt_fanout.sv
module xhalt_fanout
    import xhalt_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CORES-1:0]         sel_mask,
    input  logic [NUM_CORES*CAUSE_W-1:0] cause_en,
    input  logic [NUM_CORES-1:0]         core_halted,
    input  logic [NUM_CORES*CAUSE_W-1:0] halt_cause,
    output logic [NUM_CORES-1:0]         halt_req
);

    localparam logic [NUM_CORES-1:0] ONE_HOT0 = NUM_CORES'(1);

    logic [NUM_CORES-1:0] trig;
    logic [NUM_CORES-1:0] req_next;

    genvar i;
    generate
        for (i = 0; i < NUM_CORES; i++) begin : g_core
            assign trig[i] = sel_mask[i] && core_halted[i] &&
                             cause_hit(halt_cause[i*CAUSE_W +: CAUSE_W],
                                       cause_en[i*CAUSE_W +: CAUSE_W]);
            assign req_next[i] = sel_mask[i] && |(trig & ~(ONE_HOT0 << i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) halt_req <= '0;
        else     halt_req <= req_next;
    end

    AST_REQ_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (halt_req & ~$past(sel_mask)) == '0) else $error("request to unselected core"); // R7

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (|halt_req) |-> $past(|(core_halted & sel_mask))) else $error("request without halted source"); // R6

    AST_REQ_DROPS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (core_halted == '0) |=> halt_req == '0) else $error("request outlived halt"); // R8

endmodule

// File: rtl/xhalt_counter.sv
module xhalt_counter #(
    parameter int NUM_CORES = 4,
    parameter int CTR_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] frz_mask,
    input  logic [NUM_CORES-1:0] core_halted,
    output logic [CTR_W-1:0]     count
);

    logic frozen;

    assign frozen = |(frz_mask & core_halted);

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (!frozen) count <= count + CTR_W'(1);
    end

    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        |(frz_mask & core_halted) |=> $stable(count)) else $error("counter moved while frozen"); // R10

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (frz_mask & core_halted) == '0 |=> count == $past(count) + CTR_W'(1)) else $error("counter step"); // R9

endmodule

// File: rtl/xhalt_unit.sv
module xhalt_unit
    import xhalt_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CTR_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [CAUSE_W-1:0]           cmd_param,
    input  logic [NUM_CORES-1:0]         cmd_data,
    output logic [NUM_CORES-1:0]         rdbk,
    input  logic [NUM_CORES-1:0]         core_halted,
    input  logic [NUM_CORES*CAUSE_W-1:0] halt_cause,
    output logic [NUM_CORES-1:0]         halt_req,
    output logic [CTR_W-1:0]             ctr_value
);

    xh_cmd_t                      cmd;
    logic [NUM_CORES-1:0]         sel_mask;
    logic [NUM_CORES-1:0]         frz_mask;
    logic [NUM_CORES*CAUSE_W-1:0] cause_en;

    assign cmd.valid = cmd_valid;
    assign cmd.op    = xh_op_e'(cmd_op);
    assign cmd.param = cmd_param;

    xhalt_cfg #(.NUM_CORES(NUM_CORES)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cmd_data (cmd_data),
        .sel_mask (sel_mask),
        .cause_en (cause_en),
        .frz_mask (frz_mask),
        .rdbk     (rdbk)
    );

    xhalt_fanout #(.NUM_CORES(NUM_CORES)) u_fanout (
        .clk         (clk),
        .rst         (rst),
        .sel_mask    (sel_mask),
        .cause_en    (cause_en),
        .core_halted (core_halted),
        .halt_cause  (halt_cause),
        .halt_req    (halt_req)
    );

    xhalt_counter #(.NUM_CORES(NUM_CORES), .CTR_W(CTR_W)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .frz_mask    (frz_mask),
        .core_halted (core_halted),
        .count       (ctr_value)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (halt_req == '0 && rdbk == '0 && ctr_value == '0)) else $error("reset state"); // R1

endmodule

// File: tb/xhalt_unit_test.sv
`timescale 1ns/1ps
module xhalt_unit_test;

    localparam int N  = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [3:0]    cmd_param = 4'd0;
    logic [N-1:0]  cmd_data = '0;
    logic [N-1:0]  rdbk;
    logic [N-1:0]  core_halted = '0;
    logic [4*N-1:0] halt_cause = '0;
    logic [N-1:0]  halt_req;
    logic [CW-1:0] ctr_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xhalt_unit #(.NUM_CORES(N), .CTR_W(CW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_param(cmd_param), .cmd_data(cmd_data), .rdbk(rdbk),
        .core_halted(core_halted), .halt_cause(halt_cause),
        .halt_req(halt_req), .ctr_value(ctr_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [3:0] prm, input logic [N-1:0] dat,
                          input logic vld);
        @(negedge clk);
        cmd_valid = vld; cmd_op = op; cmd_param = prm; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_param = 4'd0; cmd_data = '0;
    endtask

    function automatic logic [N-1:0] exp_req(input logic [N-1:0] s, input logic [N-1:0] h,
                                             input logic [3:0] c);
        logic [N-1:0] t;
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) t[i] = s[i] & h[i] & c[i];
        for (int j = 0; j < N; j++) begin
            r[j] = 1'b0;
            for (int i = 0; i < N; i++) if (i != j && t[i]) r[j] = s[j];
        end
        return r;
    endfunction

    initial begin
        logic [CW-1:0] v0;
        repeat (3) @(negedge clk);
        check("R1 rdbk", 32'(rdbk), 0);
        check("R1 halt_req", 32'(halt_req), 0);
        check("R1 ctr_value", 32'(ctr_value), 0);
        rst = 1'b0;

        // R1: masks clear, reads return zero
        do_cmd(3'd2, 4'd0, '0, 1'b1);
        check("R1 select zero", 32'(rdbk), 0);
        do_cmd(3'd4, 4'hF, '0, 1'b1);
        check("R1 cause zero", 32'(rdbk), 0);

        // R3: core k enabled for cause bit k only
        for (int k = 0; k < N; k++) do_cmd(3'd3, 4'(1 << k), N'(1 << k), 1'b1);
        for (int p = 0; p < 16; p++) begin
            do_cmd(3'd4, 4'(p), '0, 1'b1);
            check("R4 overlap query", 32'(rdbk), 32'(p));
        end
        // R3 partial update: core0 all causes, others unchanged
        do_cmd(3'd3, 4'hF, 4'b0001, 1'b1);
        do_cmd(3'd4, 4'b0010, '0, 1'b1);
        check("R3 partial write", 32'(rdbk), 32'b0011);
        do_cmd(3'd4, 4'b1000, '0, 1'b1);
        check("R3 partial write b3", 32'(rdbk), 32'b1001);
        do_cmd(3'd3, 4'b0001, 4'b0001, 1'b1);
        do_cmd(3'd4, 4'b0010, '0, 1'b1);
        check("R3 restore", 32'(rdbk), 32'b0010);

        // R2, R6, R7: full sweep
        for (int s = 0; s < 16; s++) begin
            do_cmd(3'd1, 4'd0, N'(s), 1'b1);
            do_cmd(3'd2, 4'd0, '0, 1'b1);
            check("R2 select readback", 32'(rdbk), 32'(s));
            for (int h = 0; h < 16; h++) begin
                for (int c = 0; c < 16; c++) begin
                    @(negedge clk);
                    core_halted = N'(h);
                    halt_cause  = {4'(c), 4'(c), 4'(c), 4'(c)};
                    @(negedge clk);
                    check("R6/R7 fanout", 32'(halt_req), 32'(exp_req(N'(s), N'(h), 4'(c))));
                end
            end
        end

        // R8: hold and release
        @(negedge clk);
        core_halted = '0; halt_cause = '0;
        do_cmd(3'd1, 4'd0, 4'b1111, 1'b1);
        @(negedge clk);
        core_halted = 4'b0100; halt_cause = 16'h0400;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            check("R8 hold", 32'(halt_req), 32'b1011);
        end
        core_halted = '0; halt_cause = '0;
        @(negedge clk);
        check("R8 release", 32'(halt_req), 0);

        // R11: ignored commands
        do_cmd(3'd2, 4'd0, '0, 1'b1);
        check("R11 baseline", 32'(rdbk), 32'b1111);
        do_cmd(3'd1, 4'd0, 4'b0101, 1'b0);
        check("R11 invalid rdbk", 32'(rdbk), 32'b1111);
        do_cmd(3'd7, 4'hF, 4'b0011, 1'b1);
        check("R11 spare rdbk", 32'(rdbk), 32'b1111);
        do_cmd(3'd2, 4'd0, '0, 1'b1);
        check("R11 select kept", 32'(rdbk), 32'b1111);
        do_cmd(3'd5, 4'd0, 4'b1001, 1'b0);
        do_cmd(3'd6, 4'd0, '0, 1'b1);
        check("R11 freeze kept", 32'(rdbk), 0);

        // R5, R9, R10: freeze sweep
        for (int g = 0; g < 16; g++) begin
            @(negedge clk);
            core_halted = '0;
            do_cmd(3'd5, 4'd0, N'(g), 1'b1);
            do_cmd(3'd6, 4'd0, '0, 1'b1);
            check("R5 freeze readback", 32'(rdbk), 32'(g));
            for (int h = 0; h < 16; h++) begin
                @(negedge clk);
                core_halted = N'(h);
                v0 = ctr_value;
                @(negedge clk);
                if ((g & h) != 0) check("R10 counter hold", 32'(ctr_value), 32'(v0));
                else              check("R9 counter step", 32'(ctr_value), 32'(CW'(v0 + 1)));
            end
        end
        core_halted = '0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule